// File: doc/BRIEF.md
# USB Bus Reset and Suspend Detector

This block watches the two USB data lines and turns long-lasting line conditions into link events for a device controller. One timer machine looks for a single-ended zero (both data lines low while the device itself is not driving the bus). If that condition lasts past a reset timeout, the block raises a level that marks a bus reset in progress. When the line leaves single-ended zero, the block emits a one-cycle bus reset event.

A second, independent timer machine watches a bus-activity strobe. Its timing only runs while a watch-enable input is high. If no activity is seen for longer than a suspend timeout, the block emits a one-cycle bus idle event. It then waits until activity returns or watching is disabled before it can count again.

Both machines advance only on a one-microsecond tick strobe supplied from outside. Both timeouts are parameters in microseconds. A machine in its counting state moves to pending on the tick that finds its counter equal to the timeout. The counter starts at zero, so this happens on the (timeout+1)-th tick seen while counting.

Top module: `usb_line_event_det`

## Requirements
- R1: The line counts as single-ended zero only when dp_i=0, dn_i=0 and tx_oe_i=0. For any other combination of these three inputs, link_in_reset_o stays 0 and bus_reset_o never pulses, however many ticks arrive.
- R2: Reset counting starts on the first clock edge at which single-ended zero is sampled. Ticks on that same edge are not counted. link_in_reset_o goes to 1 right after the edge that samples the (RESET_US+1)-th tick while single-ended zero holds.
- R3: If single-ended zero ends before that tick, the reset machine returns to idle with no bus_reset_o pulse. The next attempt counts again from zero.
- R4: Once link_in_reset_o is 1, it stays 1 for as long as single-ended zero persists, whatever the ticks do.
- R5: When single-ended zero ends while link_in_reset_o is 1, bus_reset_o is 1 for exactly one cycle, right after that edge. In the same cycle link_in_reset_o is 0.
- R6: With idle_watch_en_i=1 and bus_activity_i=0, idle counting starts on the next edge. bus_idle_o pulses for exactly one cycle right after the edge that samples the (SUSPEND_US+1)-th tick.
- R7: During idle counting, bus_activity_i=1 or idle_watch_en_i=0 returns the idle machine to active with no pulse. While idle_watch_en_i=0, no bus_idle_o pulse ever occurs.
- R8: After a bus_idle_o pulse, no further pulse occurs while the bus stays idle. After activity or disable, a new pulse needs a full new timeout counted from zero.
- R9: Clock cycles without a tick do not advance either timer.
- R10: While rst_ni is 0, and directly after it, link_in_reset_o, bus_reset_o and bus_idle_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_us_i | input | 1 | One-cycle strobe once per microsecond |
| dp_i | input | 1 | Filtered D+ line level |
| dn_i | input | 1 | Filtered D- line level |
| tx_oe_i | input | 1 | Device is driving the bus |
| bus_activity_i | input | 1 | Bus activity seen this cycle |
| idle_watch_en_i | input | 1 | Enables inactivity timing |
| link_in_reset_o | output | 1 | Bus reset in progress (level) |
| bus_reset_o | output | 1 | One-cycle event when a bus reset ends |
| bus_idle_o | output | 1 | One-cycle event on bus inactivity timeout |

## Verification
The assertions take for granted that the line inputs are already synchronous and filtered, and that tick_us_i is a clean one-cycle strobe. Those assumptions let them tie each state change to the sampled line condition and tick on the same edge. The bench drives every input one nanosecond after the rising edge and raises a tick for exactly one cycle at a time, so each edge sees one settled set of inputs. A small timeout configuration lets the bench sweep every hold length from zero up to a few ticks past each timeout, in descending order. Because of that order, a counter that failed to clear would show up as an early event.

// File: rtl/usb_line_event_pkg.sv
// Package: shared state encodings for the line event detector.
// Assumes: no other package uses these names.
package usb_line_event_pkg;

    // Reset detector states
    typedef enum logic [1:0] {
        RST_IDLE  = 2'd0,
        RST_COUNT = 2'd1,
        RST_PEND  = 2'd2
    } rst_state_e;

    // Inactivity detector states
    typedef enum logic [1:0] {
        IDL_ACTIVE = 2'd0,
        IDL_COUNT  = 2'd1,
        IDL_PEND   = 2'd2
    } idle_state_e;

endpackage

// File: rtl/line_se0_decode.sv
// Module: line_se0_decode
// Decodes single-ended zero from the line levels and the device drive enable.
// Assumes: inputs are synchronous to the consumer clock and already filtered.
module line_se0_decode (
    input  logic dp_i,
    input  logic dn_i,
    input  logic tx_oe_i,
    output logic se0_o
);

    // SE0 is meaningful only while the device leaves the bus undriven
    always_comb begin
        se0_o = (dp_i == 1'b0) && (dn_i == 1'b0) && (tx_oe_i == 1'b0);
    end

endmodule

// File: rtl/bus_reset_timer.sv
// Module: bus_reset_timer
// Times a continuous SE0 in microsecond ticks. It reports a reset level once
// the timeout is passed, and a one-cycle event when the SE0 ends after that.
// Assumes: tick_us_i is a single-cycle strobe; se0_i is synchronous.
module bus_reset_timer
    import usb_line_event_pkg::*;
#(
    parameter int unsigned TIMEOUT_US = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_us_i,
    input  logic se0_i,
    output logic in_reset_o,
    output logic reset_evt_o
);

    localparam int unsigned CW = (TIMEOUT_US < 1) ? 1 : $clog2(TIMEOUT_US + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_US);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          evt_q;

    // Next-state selection for the reset machine
    always_comb begin
        state_d = state_q;
        case (state_q)
            RST_IDLE:  if (se0_i) state_d = RST_COUNT;
            RST_COUNT: begin
                if (!se0_i)                          state_d = RST_IDLE;
                else if (tick_us_i && cnt_q == LIMIT) state_d = RST_PEND;
            end
            RST_PEND:  if (!se0_i) state_d = RST_IDLE;
            default:   state_d = RST_IDLE;
        endcase
    end

    // State register and end-of-reset event register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RST_IDLE;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= (state_q == RST_PEND) && !se0_i;
        end
    end

    // Microsecond counter, live only while counting
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (state_q != RST_COUNT) begin
            cnt_q <= '0;
        end else if (tick_us_i && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign in_reset_o  = (state_q == RST_PEND);
    assign reset_evt_o = evt_q;

    // R1: without SE0 the machine cannot be in, or stay in, reset
    a_r1_no_reset_without_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !se0_i |=> !in_reset_o);
    // R3: losing SE0 while counting always returns to idle
    a_r3_abort_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RST_COUNT && !se0_i) |=> state_q == RST_IDLE);
    // R4: pending holds while SE0 persists
    a_r4_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_reset_o && se0_i) |=> in_reset_o);
    // R5: end of the reset level always produces the event
    a_r5_event_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(in_reset_o) |-> reset_evt_o);
    // R5: the event lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_evt_o |=> !reset_evt_o);
    // R9: counter frozen without a tick
    a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RST_COUNT && se0_i && !tick_us_i) |=> $stable(cnt_q));
    // R2: counter never passes its limit
    a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIMIT);

endmodule

// File: rtl/bus_idle_timer.sv
// Module: bus_idle_timer
// Times a quiet bus in microsecond ticks while watching is enabled. It gives
// a one-cycle event on timeout and then waits for activity or disable.
// Assumes: tick_us_i and activity_i are single-cycle synchronous strobes.
module bus_idle_timer
    import usb_line_event_pkg::*;
#(
    parameter int unsigned TIMEOUT_US = 3000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_us_i,
    input  logic activity_i,
    input  logic watch_en_i,
    output logic idle_evt_o
);

    localparam int unsigned CW = (TIMEOUT_US < 1) ? 1 : $clog2(TIMEOUT_US + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_US);

    idle_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          evt_q;
    logic          leave;
    logic          expire;

    // Conditions that abandon inactivity timing, and the timeout match
    always_comb begin
        leave  = activity_i || !watch_en_i;
        expire = (state_q == IDL_COUNT) && !leave && tick_us_i && (cnt_q == LIMIT);
    end

    // Next-state selection for the inactivity machine
    always_comb begin
        state_d = state_q;
        case (state_q)
            IDL_ACTIVE: if (!leave) state_d = IDL_COUNT;
            IDL_COUNT: begin
                if (leave)       state_d = IDL_ACTIVE;
                else if (expire) state_d = IDL_PEND;
            end
            IDL_PEND:   if (leave) state_d = IDL_ACTIVE;
            default:    state_d = IDL_ACTIVE;
        endcase
    end

    // State register and timeout event register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= IDL_ACTIVE;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= expire;
        end
    end

    // Microsecond counter, live only while counting
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (state_q != IDL_COUNT) begin
            cnt_q <= '0;
        end else if (tick_us_i && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle_evt_o = evt_q;

    // R7: activity or disable always returns to active
    a_r7_leave_to_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (activity_i || !watch_en_i) |=> state_q == IDL_ACTIVE);
    // R7: no event while watching is disabled
    a_r7_no_evt_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !watch_en_i |=> !idle_evt_o);
    // R6: the event lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_evt_o |=> !idle_evt_o);
    // R6: the event coincides with entry to pending
    a_r6_evt_enters_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_evt_o |-> (state_q == IDL_PEND && $past(state_q) == IDL_COUNT));
    // R9: counter frozen without a tick
    a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == IDL_COUNT && !leave && !tick_us_i) |=> $stable(cnt_q));
    // R8: counter never passes its limit
    a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIMIT);

endmodule

// File: rtl/usb_line_event_det.sv
// Module: usb_line_event_det (top)
// Turns USB line conditions into bus reset and bus inactivity events using
// two independent tick-driven timer machines.
// Assumes: line inputs are filtered and synchronous; tick strobe is external.
module usb_line_event_det #(
    parameter int unsigned RESET_US   = 3,
    parameter int unsigned SUSPEND_US = 3000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_us_i,
    input  logic dp_i,
    input  logic dn_i,
    input  logic tx_oe_i,
    input  logic bus_activity_i,
    input  logic idle_watch_en_i,
    output logic link_in_reset_o,
    output logic bus_reset_o,
    output logic bus_idle_o
);

    logic se0;

    // Line condition decode
    line_se0_decode u_se0 (
        .dp_i    (dp_i),
        .dn_i    (dn_i),
        .tx_oe_i (tx_oe_i),
        .se0_o   (se0)
    );

    // Bus reset timing
    bus_reset_timer #(.TIMEOUT_US(RESET_US)) u_rst (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_us_i   (tick_us_i),
        .se0_i       (se0),
        .in_reset_o  (link_in_reset_o),
        .reset_evt_o (bus_reset_o)
    );

    // Bus inactivity timing
    bus_idle_timer #(.TIMEOUT_US(SUSPEND_US)) u_idle (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_us_i  (tick_us_i),
        .activity_i (bus_activity_i),
        .watch_en_i (idle_watch_en_i),
        .idle_evt_o (bus_idle_o)
    );

    // R10: nothing reported in the cycle after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk_i)
        !rst_ni |=> (!link_in_reset_o && !bus_reset_o && !bus_idle_o));

endmodule

// File: tb/test_usb_line_event_det.sv
// Bench: timeout sweeps over a small configuration.
module test_usb_line_event_det;

    localparam int R_T = 3;
    localparam int S_T = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic dp = 1'b1, dn = 1'b0, oe = 1'b0;
    logic act = 1'b1, en = 1'b1;
    logic in_rst, rst_evt, idle_evt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    usb_line_event_det #(.RESET_US(R_T), .SUSPEND_US(S_T)) i_usb_line_event_det (
        .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick),
        .dp_i(dp), .dn_i(dn), .tx_oe_i(oe),
        .bus_activity_i(act), .idle_watch_en_i(en),
        .link_in_reset_o(in_rst), .bus_reset_o(rst_evt), .bus_idle_o(idle_evt)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One clock cycle; inputs change and outputs are sampled 1 ns after the edge
    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    initial begin
        // R10: reset state
        repeat (3) cyc(1'b1);
        chk(in_rst, 1'b0, "R10 in reset");
        chk(rst_evt, 1'b0, "R10 in reset");
        chk(idle_evt, 1'b0, "R10 in reset");
        rst_n = 1'b1;
        cyc(1'b0);
        chk(in_rst | rst_evt | idle_evt, 1'b0, "R10 after reset");

        // R1: every non-SE0 combination of dp, dn, oe
        for (int c = 1; c < 8; c++) begin
            {dp, dn, oe} = c[2:0];
            cyc(1'b0);
            for (int i = 0; i < R_T + 3; i++) begin
                cyc(1'b1);
                chk(in_rst, 1'b0, "R1 not SE0");
            end
            {dp, dn, oe} = 3'b100;
            cyc(1'b0);
            chk(rst_evt, 1'b0, "R1 no event");
        end

        // R2 R3 R4 R5: hold SE0 for n ticks, descending
        for (int n = R_T + 3; n >= 0; n--) begin
            {dp, dn, oe} = 3'b000;
            cyc(1'b0);
            chk(in_rst, 1'b0, "R2 start of count");
            for (int i = 1; i <= n; i++) begin
                cyc(1'b1);
                chk(in_rst, (i >= R_T + 1) ? 1'b1 : 1'b0,
                    (i > R_T + 1) ? "R4 hold" : "R2 timeout");
            end
            {dp, dn, oe} = 3'b100;
            cyc(1'b0);
            chk(rst_evt, (n >= R_T + 1) ? 1'b1 : 1'b0,
                (n >= R_T + 1) ? "R5 event" : "R3 early end");
            chk(in_rst, 1'b0, "R5 level drop");
            cyc(1'b0);
            chk(rst_evt, 1'b0, "R5 single cycle");
        end

        // R9: no progress without ticks
        {dp, dn, oe} = 3'b000;
        cyc(1'b0);
        repeat (20) begin
            cyc(1'b0);
            chk(in_rst, 1'b0, "R9 reset no tick");
        end
        for (int i = 1; i <= R_T + 1; i++) begin
            cyc(1'b1);
            chk(in_rst, (i == R_T + 1) ? 1'b1 : 1'b0, "R9 reset resumes");
        end
        {dp, dn, oe} = 3'b100;
        cyc(1'b0);
        chk(rst_evt, 1'b1, "R5 after R9");
        cyc(1'b0);

        // R6 R7 R8: quiet bus for n ticks, descending
        for (int n = S_T + 4; n >= 0; n--) begin
            act = 1'b0;
            en  = 1'b1;
            cyc(1'b0);
            chk(idle_evt, 1'b0, "R6 start of count");
            for (int i = 1; i <= n; i++) begin
                cyc(1'b1);
                chk(idle_evt, (i == S_T + 1) ? 1'b1 : 1'b0,
                    (i > S_T + 1) ? "R8 no repeat" : "R6 timeout");
            end
            if (n % 2 == 1) act = 1'b1;
            else            en  = 1'b0;
            cyc(1'b1);
            chk(idle_evt, 1'b0, "R7 leave");
            act = 1'b1;
            en  = 1'b1;
            cyc(1'b0);
        end

        // R7: watching disabled on a quiet bus
        act = 1'b0;
        en  = 1'b0;
        for (int i = 0; i < 3 * S_T; i++) begin
            cyc(1'b1);
            chk(idle_evt, 1'b0, "R7 disabled");
        end
        en = 1'b1;
        cyc(1'b0);
        // R9: idle timer ignores tickless cycles
        repeat (10) begin
            cyc(1'b0);
            chk(idle_evt, 1'b0, "R9 idle no tick");
        end
        for (int i = 1; i <= S_T + 1; i++) begin
            cyc(1'b1);
            chk(idle_evt, (i == S_T + 1) ? 1'b1 : 1'b0, "R6 after enable");
        end
        act = 1'b1;
        cyc(1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule